// File: doc/BRIEF.md
# Cache Line Refill Bus Master

This block drives a Wishbone bus for the miss path of a data cache. When the miss controller presents a request, the block reads the request attributes once, at acceptance, and decides how to serve it. A cacheable read miss is fetched as a burst covering the whole cache line: every byte lane is enabled, cab stays asserted, and the word address steps once per acknowledged beat. Any other access gets one ordinary transfer that carries the requester's own byte select. That covers a write, an inhibited read, a read with the cache disabled, and a read that hit.

The burst decision is held in a register for the whole transaction. The all-lanes select and cab are derived from that register, never from the live inhibit input. A glitch on inhibit in the middle of a refill therefore cannot change the byte select. If the byte select dropped, an acknowledge that arrives too early could be taken as line data. There are two sources of inhibit: an explicit inhibit input, and (when the UNCACHED_MSB parameter is set) the top address bit, which stands in for the inhibit decision when address translation is off.

The block also handles three bus responses and one requester action. On retry it drops the strobe for one cycle and reissues the same beat. On error it ends the transaction. If the requester withdraws by raising abort, the beat already on the bus is finished with all of its bus outputs held, and no later beat is issued.

Top module: `line_fill_master`

## Requirements
- R1: After reset, cyc_o, stb_o and cab_o are low, sel_o is zero, and rvalid_o, done_o and err_o are low.
- R2: A request is a burst when it is a read (we_i=0), cache_en_i=1, miss_i=1, inhibit_i=0, and (if UNCACHED_MSB=1) addr_i bit ADDR_W-1 is 0. A burst issues LINE_WORDS beats. Beat k uses the address line base + 4*k, where the line base is addr_i with its low log2(LINE_WORDS)+2 bits cleared. Every beat has sel_o all ones and cab_o high.
- R3: While cyc_o stays high from one cycle to the next, sel_o and cab_o do not change.
- R4: Changes on inhibit_i, cache_en_i, miss_i and sel_i after a request is accepted have no effect on that transaction.
- R5: A request that is not a burst issues exactly one transfer. That transfer has adr_o equal to addr_i with its low 2 bits cleared, sel_o equal to sel_i, and cab_o low.
- R6: rvalid_o pulses in the cycle after each acknowledged read beat, and rdata_o then holds the dat_i value sampled with that ack. rvalid_o is never high at any other time.
- R7: done_o pulses once, in the cycle after the final ack. For a read this is the same cycle as the last rvalid_o.
- R8: cyc_o and stb_o are low in the cycle after the final ack. A retry response drops cyc_o and stb_o for exactly one cycle, and the same beat is then reissued.
- R9: An err response ends the transaction. In the next cycle cyc_o is low and done_o and err_o pulse together.
- R10: If abort_i is high while a beat is outstanding, cyc_o, stb_o, adr_o, sel_o and cab_o hold until that beat gets ack, err or rty. The bus is then released, done_o does not pulse, and no further beat is issued.
- R11: A write is always a single transfer, even when cache_en_i and miss_i are set. It has we_o high, dat_o equal to wdata_i, and sel_o equal to sel_i.
- R12: req_i is ignored while a transaction is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Request from the miss controller, sampled when idle |
| addr_i | input | ADDR_W | Byte address of the access |
| sel_i | input | DATA_W/8 | Requester byte select |
| we_i | input | 1 | 1 = write, 0 = read |
| wdata_i | input | DATA_W | Write data |
| cache_en_i | input | 1 | Cache enabled |
| miss_i | input | 1 | Tag compare reports a miss |
| inhibit_i | input | 1 | Access is cache-inhibited |
| abort_i | input | 1 | Requester withdraws the transaction |
| rdata_o | output | DATA_W | Data of the last acknowledged read beat |
| rvalid_o | output | 1 | rdata_o is new this cycle |
| done_o | output | 1 | Transaction completed |
| err_o | output | 1 | Transaction ended with a bus error |
| cyc_o | output | 1 | Bus cycle |
| stb_o | output | 1 | Bus strobe |
| cab_o | output | 1 | Burst (consecutive address) in progress |
| we_o | output | 1 | Bus write enable |
| sel_o | output | DATA_W/8 | Bus byte select |
| adr_o | output | ADDR_W | Bus byte address |
| dat_o | output | DATA_W | Bus write data |
| dat_i | input | DATA_W | Bus read data |
| ack_i | input | 1 | Bus acknowledge |
| err_i | input | 1 | Bus error response |
| rty_i | input | 1 | Bus retry response |

## Verification
The bench builds the block with ADDR_W=16, DATA_W=32, LINE_WORDS=4 and UNCACHED_MSB=1.

With a 16-bit address, address bit 15 can be swept both ways. The sweep covers every combination of the five inputs that decide burst versus single, for both reads and writes, at zero, one and two wait states. While each transaction runs, the bench keeps toggling inhibit, the byte select and stray requests.

A four-word line keeps each burst short enough that retry, error and abort can be placed on the first beat, a middle beat and the last beat. The bench also hits the case where abort arrives during wait states and must hold the outstanding beat.

// File: rtl/lfm_pkg.sv
package lfm_pkg;

    typedef enum logic [1:0] {
        LFM_IDLE  = 2'd0,
        LFM_BUS   = 2'd1,
        LFM_RETRY = 2'd2,
        LFM_DRAIN = 2'd3
    } lfm_state_e;

endpackage

// File: rtl/lfm_burst_decide.sv
// Decides at acceptance whether a request becomes a line burst.
module lfm_burst_decide #(
    parameter bit UNCACHED_MSB = 1'b1
) (
    input  logic cache_en_i,
    input  logic miss_i,
    input  logic we_i,
    input  logic inhibit_i,
    input  logic addr_msb_i,
    output logic burst_o
);
    logic inhibited;

    generate
        if (UNCACHED_MSB) begin : g_msb_inhibit
            // without translation the top address bit marks uncached space
            assign inhibited = inhibit_i | addr_msb_i;
        end else begin : g_pin_inhibit
            logic unused_msb;
            assign unused_msb = addr_msb_i;
            assign inhibited  = inhibit_i;
        end
    endgenerate

    assign burst_o = cache_en_i & miss_i & ~we_i & ~inhibited;
endmodule

// File: rtl/lfm_beat_ctr.sv
// Word index inside the line; advances once per accepted beat.
module lfm_beat_ctr #(
    parameter int LINE_WORDS = 4,
    localparam int IDX_W = $clog2(LINE_WORDS)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             clear_i,
    input  logic             step_i,
    output logic [IDX_W-1:0] cnt_o,
    output logic             last_o
);
    logic [IDX_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clear_i) begin
            cnt_d = '0;
        end else if (step_i) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt_o  = cnt_q;
    assign last_o = (cnt_q == IDX_W'(LINE_WORDS - 1));
endmodule

// File: rtl/lfm_sel_gen.sv
// Byte select toward the bus, gated by the latched burst flag only.
module lfm_sel_gen #(
    parameter int SEL_W = 4
) (
    input  logic             burst_i,
    input  logic [SEL_W-1:0] cpu_sel_i,
    output logic [SEL_W-1:0] sel_o
);
    assign sel_o = burst_i ? {SEL_W{1'b1}} : cpu_sel_i;
endmodule

// File: rtl/line_fill_master.sv
module line_fill_master
    import lfm_pkg::*;
#(
    parameter int ADDR_W       = 32,
    parameter int DATA_W       = 32,
    parameter int LINE_WORDS   = 4,
    parameter bit UNCACHED_MSB = 1'b1
) (
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic                req_i,
    input  logic [ADDR_W-1:0]   addr_i,
    input  logic [DATA_W/8-1:0] sel_i,
    input  logic                we_i,
    input  logic [DATA_W-1:0]   wdata_i,
    input  logic                cache_en_i,
    input  logic                miss_i,
    input  logic                inhibit_i,
    input  logic                abort_i,
    output logic [DATA_W-1:0]   rdata_o,
    output logic                rvalid_o,
    output logic                done_o,
    output logic                err_o,
    output logic                cyc_o,
    output logic                stb_o,
    output logic                cab_o,
    output logic                we_o,
    output logic [DATA_W/8-1:0] sel_o,
    output logic [ADDR_W-1:0]   adr_o,
    output logic [DATA_W-1:0]   dat_o,
    input  logic [DATA_W-1:0]   dat_i,
    input  logic                ack_i,
    input  logic                err_i,
    input  logic                rty_i
);
    localparam int SEL_W  = DATA_W / 8;
    localparam int BYTE_W = $clog2(SEL_W);
    localparam int IDX_W  = $clog2(LINE_WORDS);
    localparam int HI_W   = ADDR_W - IDX_W - BYTE_W;

    typedef struct packed {
        lfm_state_e        st;
        logic [ADDR_W-1:0] addr;
        logic [SEL_W-1:0]  sel;
        logic              we;
        logic [DATA_W-1:0] wdata;
        logic              burst;
        logic [DATA_W-1:0] rdata;
        logic              rvalid;
        logic              done;
        logic              err;
    } regs_t;

    regs_t r_d, r_q;

    logic             burst_w;
    logic             ctr_clear, ctr_step, ctr_last;
    logic [IDX_W-1:0] ctr_cnt;

    lfm_burst_decide #(
        .UNCACHED_MSB(UNCACHED_MSB)
    ) u_decide (
        .cache_en_i (cache_en_i),
        .miss_i     (miss_i),
        .we_i       (we_i),
        .inhibit_i  (inhibit_i),
        .addr_msb_i (addr_i[ADDR_W-1]),
        .burst_o    (burst_w)
    );

    lfm_beat_ctr #(
        .LINE_WORDS(LINE_WORDS)
    ) u_ctr (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .clear_i (ctr_clear),
        .step_i  (ctr_step),
        .cnt_o   (ctr_cnt),
        .last_o  (ctr_last)
    );

    lfm_sel_gen #(
        .SEL_W(SEL_W)
    ) u_sel (
        .burst_i   (r_q.burst),
        .cpu_sel_i (r_q.sel),
        .sel_o     (sel_o)
    );

    always_comb begin
        r_d        = r_q;
        r_d.rvalid = 1'b0;
        r_d.done   = 1'b0;
        r_d.err    = 1'b0;
        ctr_clear  = 1'b0;
        ctr_step   = 1'b0;

        unique case (r_q.st)
            LFM_IDLE: begin
                if (req_i) begin
                    // every attribute is frozen here for the whole transaction
                    r_d.st    = LFM_BUS;
                    r_d.addr  = {addr_i[ADDR_W-1:BYTE_W], {BYTE_W{1'b0}}};
                    r_d.sel   = sel_i;
                    r_d.we    = we_i;
                    r_d.wdata = wdata_i;
                    r_d.burst = burst_w;
                    ctr_clear = 1'b1;
                end
            end

            LFM_BUS: begin
                if (err_i) begin
                    r_d.st    = LFM_IDLE;
                    r_d.burst = 1'b0;
                    r_d.done  = 1'b1;
                    r_d.err   = 1'b1;
                end else if (ack_i) begin
                    if (!r_q.we) begin
                        r_d.rvalid = 1'b1;
                        r_d.rdata  = dat_i;
                    end
                    if (!r_q.burst || ctr_last) begin
                        r_d.st    = LFM_IDLE;
                        r_d.burst = 1'b0;
                        r_d.done  = 1'b1;
                    end else if (abort_i) begin
                        r_d.st    = LFM_IDLE;
                        r_d.burst = 1'b0;
                    end else begin
                        ctr_step = 1'b1;
                    end
                end else if (rty_i) begin
                    if (abort_i) begin
                        r_d.st    = LFM_IDLE;
                        r_d.burst = 1'b0;
                    end else begin
                        r_d.st = LFM_RETRY;
                    end
                end else if (abort_i) begin
                    // beat is on the bus: keep every output until it resolves
                    r_d.st = LFM_DRAIN;
                end
            end

            LFM_RETRY: begin
                if (abort_i) begin
                    r_d.st    = LFM_IDLE;
                    r_d.burst = 1'b0;
                end else begin
                    r_d.st = LFM_BUS;
                end
            end

            LFM_DRAIN: begin
                if (ack_i || err_i || rty_i) begin
                    r_d.st    = LFM_IDLE;
                    r_d.burst = 1'b0;
                    if (ack_i && !r_q.we) begin
                        r_d.rvalid = 1'b1;
                        r_d.rdata  = dat_i;
                    end
                end
            end

            default: r_d.st = LFM_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign cyc_o    = (r_q.st == LFM_BUS) || (r_q.st == LFM_DRAIN);
    assign stb_o    = cyc_o;
    assign cab_o    = r_q.burst;
    assign we_o     = r_q.we;
    assign dat_o    = r_q.wdata;
    assign rdata_o  = r_q.rdata;
    assign rvalid_o = r_q.rvalid;
    assign done_o   = r_q.done;
    assign err_o    = r_q.err;

    logic [HI_W-1:0] line_hi;
    assign line_hi = r_q.addr[ADDR_W-1 -: HI_W];
    assign adr_o   = r_q.burst ? {line_hi, ctr_cnt, {BYTE_W{1'b0}}} : r_q.addr;
endmodule

// File: rtl/lfm_checker.sv
module lfm_checker #(
    parameter int ADDR_W = 32,
    parameter int SEL_W  = 4
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              cyc_o,
    input logic              stb_o,
    input logic              cab_o,
    input logic [SEL_W-1:0]  sel_o,
    input logic [ADDR_W-1:0] adr_o,
    input logic              ack_i,
    input logic              err_i,
    input logic              rty_i,
    input logic              abort_i,
    input logic              rvalid_o,
    input logic              done_o,
    input logic              err_o
);
    // R2: a burst beat enables every byte lane
    a_r2_all_lanes: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_o && cab_o |-> sel_o == {SEL_W{1'b1}});

    // R3: select and cab frozen across consecutive bus cycles
    a_r3_sel_frozen: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_o && $past(cyc_o) |-> $stable(sel_o) && $stable(cab_o));

    // R6: read data is only presented after an ack
    a_r6_data_on_ack: assert property (@(posedge clk_i) disable iff (!rst_ni)
        rvalid_o |-> $past(ack_i && cyc_o));

    // R7: completion reported only with the bus released
    a_r7_done_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
        done_o |-> !cyc_o);

    // R8: retry frees the bus for a cycle
    a_r8_retry_gap: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_o && rty_i && !ack_i && !err_i |=> !cyc_o && !stb_o);

    // R9: bus error ends the transaction with both flags
    a_r9_err_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_o && err_i |=> !cyc_o && err_o && done_o);

    // R10: an abort keeps the outstanding beat on the bus
    a_r10_abort_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        cyc_o && abort_i && !ack_i && !err_i && !rty_i |=> cyc_o && $stable(adr_o));
endmodule

bind line_fill_master lfm_checker #(
    .ADDR_W (ADDR_W),
    .SEL_W  (DATA_W / 8)
) u_lfm_checker (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .cyc_o    (cyc_o),
    .stb_o    (stb_o),
    .cab_o    (cab_o),
    .sel_o    (sel_o),
    .adr_o    (adr_o),
    .ack_i    (ack_i),
    .err_i    (err_i),
    .rty_i    (rty_i),
    .abort_i  (abort_i),
    .rvalid_o (rvalid_o),
    .done_o   (done_o),
    .err_o    (err_o)
);

// File: tb/line_fill_master_bench.sv
module line_fill_master_bench;
    localparam int AW = 16;
    localparam int DW = 32;
    localparam int LW = 4;

    logic          clk_i = 1'b0;
    logic          rst_ni = 1'b0;
    logic          req_i = 1'b0;
    logic [AW-1:0] addr_i = '0;
    logic [3:0]    sel_i = '0;
    logic          we_i = 1'b0;
    logic [DW-1:0] wdata_i = '0;
    logic          cache_en_i = 1'b0;
    logic          miss_i = 1'b0;
    logic          inhibit_i = 1'b0;
    logic          abort_i = 1'b0;
    logic [DW-1:0] rdata_o;
    logic          rvalid_o, done_o, err_o;
    logic          cyc_o, stb_o, cab_o, we_o;
    logic [3:0]    sel_o;
    logic [AW-1:0] adr_o;
    logic [DW-1:0] dat_o;
    logic [DW-1:0] dat_i = '0;
    logic          ack_i = 1'b0;
    logic          err_i = 1'b0;
    logic          rty_i = 1'b0;

    int n_cmp = 0;
    int n_mis = 0;

    always #5 clk_i = ~clk_i;

    line_fill_master #(
        .ADDR_W(AW), .DATA_W(DW), .LINE_WORDS(LW), .UNCACHED_MSB(1'b1)
    ) u_line_fill_master (
        .clk_i(clk_i), .rst_ni(rst_ni), .req_i(req_i), .addr_i(addr_i),
        .sel_i(sel_i), .we_i(we_i), .wdata_i(wdata_i), .cache_en_i(cache_en_i),
        .miss_i(miss_i), .inhibit_i(inhibit_i), .abort_i(abort_i),
        .rdata_o(rdata_o), .rvalid_o(rvalid_o), .done_o(done_o), .err_o(err_o),
        .cyc_o(cyc_o), .stb_o(stb_o), .cab_o(cab_o), .we_o(we_o), .sel_o(sel_o),
        .adr_o(adr_o), .dat_o(dat_o), .dat_i(dat_i), .ack_i(ack_i),
        .err_i(err_i), .rty_i(rty_i)
    );

    function automatic logic [DW-1:0] mem_at(input logic [AW-1:0] a);
        return {a, ~a} ^ 32'h5A3C_96E1;
    endfunction

    task automatic chk(input bit ok, input string tag,
                       input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_cmp++;
        if (!ok) begin
            n_mis++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // One transaction: negative beat indices disable retry/err/abort injection.
    task automatic run_txn(input logic [AW-1:0] addr, input logic [3:0] sel,
                           input bit we, input bit cen, input bit miss, input bit inh,
                           input int wait_n, input int rty_beat, input int err_beat,
                           input int abort_beat);
        bit            burst;
        int            total, exp_beats, exp_rv, exp_done, exp_err;
        int            beat, waitc, ended, n_rv, n_done, n_err;
        bit            rty_done, gap, aborted;
        logic [AW-1:0] acked [8];
        logic [AW-1:0] exp_adr;
        logic [DW-1:0] wd;

        burst    = cen && miss && !we && !inh && !addr[AW-1];
        total    = burst ? LW : 1;
        aborted  = abort_beat >= 0 && abort_beat < total &&
                   !(abort_beat == total - 1 && wait_n == 0);
        exp_err  = (err_beat >= 0 && err_beat < total) ? 1 : 0;
        if (exp_err != 0) begin
            exp_beats = err_beat; exp_done = 1;
        end else if (aborted) begin
            exp_beats = abort_beat + 1; exp_done = 0;
        end else begin
            exp_beats = total; exp_done = 1;
        end
        exp_rv = we ? 0 : exp_beats;
        wd     = mem_at(addr) ^ 32'hFFFF_0000;

        addr_i = addr; sel_i = sel; we_i = we; wdata_i = wd;
        cache_en_i = cen; miss_i = miss; inhibit_i = inh; req_i = 1'b1;
        @(negedge clk_i);
        req_i = 1'b0;
        beat = 0; waitc = 0; ended = 0; n_rv = 0; n_done = 0; n_err = 0;
        rty_done = 1'b0; gap = 1'b0;
        for (int i = 0; i < 28; i++) begin
            if (rvalid_o) begin
                n_rv++;
                chk(rdata_o == mem_at(acked[(n_rv-1) & 7]), "R6 read data", rdata_o,
                    mem_at(acked[(n_rv-1) & 7]));
            end
            if (done_o) begin
                n_done++;
                if (!we && exp_err == 0)
                    chk(rvalid_o, "R7 done with last data", {31'd0, rvalid_o}, 1);
            end
            if (err_o) n_err++;
            if (gap) begin
                chk(!cyc_o && !stb_o, "R8 retry gap", {31'd0, cyc_o}, 0);
                gap = 1'b0;
            end
            if (ended == 1) begin
                chk(!cyc_o, "R8 bus released after end", {31'd0, cyc_o}, 0);
                ended = 2;
            end else if (ended == 2 && cyc_o) begin
                chk(1'b0, "R10 R12 beat after end", {31'd0, cyc_o}, 0);
                ended = 3;
            end
            ack_i = 1'b0; rty_i = 1'b0; err_i = 1'b0;
            if (cyc_o && ended == 0) begin
                exp_adr = burst ? ((addr & ~AW'(15)) + AW'(beat * 4)) : (addr & ~AW'(3));
                chk(adr_o == exp_adr, burst ? "R2 beat address" : "R5 single address",
                    {16'd0, adr_o}, {16'd0, exp_adr});
                chk(sel_o == (burst ? 4'hF : sel), burst ? "R2 R3 R4 sel" : "R5 R4 sel",
                    {28'd0, sel_o}, {28'd0, burst ? 4'hF : sel});
                chk(cab_o == burst, "R2 R5 cab", {31'd0, cab_o}, {31'd0, burst});
                if (we) chk(we_o && dat_o == wd, "R11 write data", dat_o, wd);
                if (beat == abort_beat) abort_i = 1'b1;
                if (waitc < wait_n) begin
                    waitc++;
                end else begin
                    waitc = 0;
                    if (beat == rty_beat && !rty_done) begin
                        rty_i = 1'b1; rty_done = 1'b1; gap = 1'b1;
                    end else if (beat == err_beat) begin
                        err_i = 1'b1; ended = 1;
                    end else begin
                        ack_i = 1'b1; dat_i = mem_at(adr_o); acked[beat & 7] = adr_o;
                        beat++;
                        if (beat == total || abort_i) ended = 1;
                    end
                end
            end
            // disturbances that must not affect the running transaction (R4, R12)
            inhibit_i  = ~inhibit_i;
            cache_en_i = ~cache_en_i;
            miss_i     = ~miss_i;
            sel_i      = ~sel_i;
            addr_i     = addr ^ 16'h7FF0;
            req_i      = cyc_o;
            @(negedge clk_i);
        end
        req_i = 1'b0; abort_i = 1'b0; ack_i = 1'b0; rty_i = 1'b0; err_i = 1'b0;
        chk(beat == exp_beats, "R2 R5 R10 beat count", beat, exp_beats);
        chk(n_rv == exp_rv, "R6 rvalid count", n_rv, exp_rv);
        chk(n_done == exp_done, "R7 R10 done count", n_done, exp_done);
        chk(n_err == exp_err, "R9 err count", n_err, exp_err);
    endtask

    initial begin
        repeat (150000) @(posedge clk_i);
        n_cmp++; n_mis++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk_i);
        // R1: reset state
        chk(!cyc_o && !stb_o && !cab_o, "R1 bus idle in reset", {29'd0, cyc_o, stb_o, cab_o}, 0);
        chk(sel_o == 4'h0, "R1 sel zero", {28'd0, sel_o}, 0);
        chk(!rvalid_o && !done_o && !err_o, "R1 flags low", {29'd0, rvalid_o, done_o, err_o}, 0);
        rst_ni = 1'b1;
        @(negedge clk_i);
        chk(!cyc_o && !done_o, "R1 idle after release", {30'd0, cyc_o, done_o}, 0);

        // sweep of all decision inputs, read and write, three wait depths
        for (int c = 0; c < 32; c++) begin
            for (int w = 0; w < 3; w++) begin
                logic [AW-1:0] a;
                a = AW'(c * 16'h0431 + w * 16'h0107);
                a[AW-1] = c[3];
                run_txn(a, 4'((c + w) % 15 + 1), c[4], c[0], c[1], c[2], w, -1, -1, -1);
            end
        end

        // R8 retry on first, middle and single beats
        run_txn(16'h0124, 4'h3, 1'b0, 1'b1, 1'b1, 1'b0, 0, 0, -1, -1);
        run_txn(16'h0238, 4'h3, 1'b0, 1'b1, 1'b1, 1'b0, 1, 2, -1, -1);
        run_txn(16'h8010, 4'h6, 1'b0, 1'b1, 1'b1, 1'b0, 0, 0, -1, -1);
        run_txn(16'h0044, 4'h9, 1'b1, 1'b1, 1'b1, 1'b0, 2, 0, -1, -1);
        // R9 error on first, middle, last beat and single
        run_txn(16'h0350, 4'h1, 1'b0, 1'b1, 1'b1, 1'b0, 0, -1, 0, -1);
        run_txn(16'h0364, 4'h1, 1'b0, 1'b1, 1'b1, 1'b0, 1, -1, 2, -1);
        run_txn(16'h0378, 4'h1, 1'b0, 1'b1, 1'b1, 1'b0, 0, -1, 3, -1);
        run_txn(16'h0380, 4'hC, 1'b0, 1'b0, 1'b1, 1'b0, 2, -1, 0, -1);
        // R10 abort with immediate ack, during wait states, and on a single
        run_txn(16'h0400, 4'h2, 1'b0, 1'b1, 1'b1, 1'b0, 0, -1, -1, 1);
        run_txn(16'h0410, 4'h2, 1'b0, 1'b1, 1'b1, 1'b0, 2, -1, -1, 0);
        run_txn(16'h0420, 4'h2, 1'b0, 1'b1, 1'b1, 1'b0, 3, -1, -1, 3);
        run_txn(16'h0434, 4'h5, 1'b0, 1'b1, 1'b1, 1'b1, 2, -1, -1, 0);
        run_txn(16'h0448, 4'hA, 1'b1, 1'b1, 1'b1, 1'b0, 1, -1, -1, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_mis);
        $finish;
    end
endmodule